// File: doc/BRIEF.md
# Prescaled Two-Channel Countdown Timer

A register-mapped timer block with two identical down-counting channels. Each channel owns a control word, a 32-bit reload word and a read-only live-count word. Each channel also has an 8-bit prescaler that lets the counter step once every (prescale + 1) clock cycles. A channel runs either once, stopping itself at expiry, or periodically, reloading from its reload word each time it reaches the end of its count.

Expiry of a channel latches a flag in a shared status word. Software acknowledges a flag by writing a one to its bit. Each channel drives its own interrupt line, which is the latched flag qualified by that channel's interrupt-enable bit. Software arms a one-shot event by writing the reload word and then writing the control word with the run, interrupt-enable and prescale fields set. The inverted live count gives a rising timebase when a channel runs periodically from 0xFFFFFFFF.

Top module: `ptmr_top`

## Requirements
- R1: After reset every mapped register reads zero and both interrupt outputs are low.
- R2: Control word fields: bit 30 run, bit 29 interrupt enable, bits 28:27 mode (00 one-shot, 01 periodic), bits 7:0 prescale. All other bits read back as zero (readback mask 0x780000FF).
- R3: While running, the live count drops by one every (prescale + 1) clock cycles, with no step in between.
- R4: A control write with bit 30 set loads the live count from the reload word on that edge and restarts the prescaler phase, so the first step comes (prescale + 1) cycles later.
- R5: In one-shot mode, the step that takes the count from 1 to 0 is the expiry. On that edge the channel sets its flag, clears its run bit and then holds the count at 0.
- R6: In periodic mode, the expiry step loads the count from the reload word and the channel keeps running, so expiries repeat every reload × (prescale + 1) cycles.
- R7: The status word at word address 6 holds channel i's flag in bit i. Writing a 1 to a bit clears that flag, and writing 0 to a bit leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R8: irq_o[i] is high exactly when channel i's flag is set and its interrupt-enable bit is 1.
- R9: A control write with bit 30 clear stops the channel. Its live count then holds its value.
- R10: Writes to a live-count word are ignored. A reload-word write during a countdown does not change that countdown and takes effect at the next load or reload.
- R11: Word address map: channel i control at 3i, reload at 3i+1, live count at 3i+2, status at 6. Address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Word address |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 2 | Per-channel interrupt |

## Verification
Internal errors show at the ports within one count period. A prescaler phase that is not cleared on start shifts every live-count read by up to a prescale window. A lost reload shows up as a wrong live count on the first read after expiry, or as a one-shot run bit that stays set. A flag race between clear and expiry appears on the very next status read and on irq_o. The bench therefore reads the live count at random cycle offsets across expiry boundaries and compares each read with a closed-form expectation.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int DATA_W      = 32;
  localparam int PRE_W       = 8;
  localparam int REGS_PER_CH = 3;
  localparam int OFS_CTRL    = 0;
  localparam int OFS_LOAD    = 1;
  localparam int OFS_COUNT   = 2;

  localparam int BIT_RUN     = 30;
  localparam int BIT_IE      = 29;
  localparam int BIT_MODE_HI = 28;
  localparam int BIT_MODE_LO = 27;

  localparam logic [1:0] MODE_ONESHOT  = 2'b00;
  localparam logic [1:0] MODE_PERIODIC = 2'b01;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] phase_q;
  logic             at_end;

  assign at_end = (phase_q == div_i);
  assign tick_o = run_i & ~restart_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (run_i)     phase_q <= at_end ? '0 : phase_q + PRE_W'(1);
  end

  // phase never passes the divider while running
  assert_phase_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !restart_i |-> phase_q <= div_i);
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
  import ptmr_pkg::*;
#(
  parameter int CNT_W = DATA_W,
  parameter int PW    = PRE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              load_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              expire_o,
  output logic              irq_en_o
);
  logic             run_q, ie_q;
  logic [1:0]       mode_q;
  logic [PW-1:0]    presc_q;
  logic [CNT_W-1:0] load_q, count_q;
  logic             tick, last, periodic;

  ptmr_prescaler #(.PRE_W(PW)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .restart_i(ctrl_we_i),
    .div_i    (presc_q),
    .tick_o   (tick)
  );

  assign last     = (count_q <= CNT_W'(1));
  assign periodic = (mode_q == MODE_PERIODIC);
  assign expire_o = tick & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= '0;
    else if (load_we_i) load_q <= wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      ie_q    <= 1'b0;
      mode_q  <= MODE_ONESHOT;
      presc_q <= '0;
      count_q <= '0;
    end else if (ctrl_we_i) begin
      run_q   <= wdata_i[BIT_RUN];
      ie_q    <= wdata_i[BIT_IE];
      mode_q  <= wdata_i[BIT_MODE_HI:BIT_MODE_LO];
      presc_q <= wdata_i[PW-1:0];
      if (wdata_i[BIT_RUN]) count_q <= load_q;
    end else if (tick) begin
      if (!last) begin
        count_q <= count_q - CNT_W'(1);
      end else if (periodic) begin
        count_q <= load_q;
      end else begin
        count_q <= '0;
        run_q   <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[BIT_RUN] = run_q;
    ctrl_o[BIT_IE]  = ie_q;
    ctrl_o[BIT_MODE_HI:BIT_MODE_LO] = mode_q;
    ctrl_o[PW-1:0]  = presc_q;
  end

  assign load_o   = load_q;
  assign count_o  = count_q;
  assign irq_en_o = ie_q;

  assert_start_loads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && wdata_i[BIT_RUN] |=> count_q == $past(load_q));
  assert_step_only_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick && !ctrl_we_i |=> $stable(count_q));
  assert_oneshot_halt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !periodic && !ctrl_we_i |=> !run_q && count_q == '0);
  assert_periodic_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && periodic && !ctrl_we_i |=> run_q && count_q == $past(load_q));
  assert_stopped_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !ctrl_we_i |=> $stable(count_q));
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int N_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  localparam int ADDR_W      = 3;
  localparam int STATUS_ADDR = REGS_PER_CH * N_CH;

  logic [DATA_W-1:0] ctrl_rd  [N_CH];
  logic [DATA_W-1:0] load_rd  [N_CH];
  logic [DATA_W-1:0] count_rd [N_CH];
  logic [N_CH-1:0]   expire, irq_en, flag_q, clr;
  logic              status_we;

  assign status_we = we_i && (addr_i == ADDR_W'(STATUS_ADDR));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic ctrl_we, load_we;
    assign ctrl_we = we_i && (addr_i == ADDR_W'(REGS_PER_CH*i + OFS_CTRL));
    assign load_we = we_i && (addr_i == ADDR_W'(REGS_PER_CH*i + OFS_LOAD));

    ptmr_channel u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctrl_we_i(ctrl_we),
      .load_we_i(load_we),
      .wdata_i  (wdata_i),
      .ctrl_o   (ctrl_rd[i]),
      .load_o   (load_rd[i]),
      .count_o  (count_rd[i]),
      .expire_o (expire[i]),
      .irq_en_o (irq_en[i])
    );

    assign clr[i]   = status_we & wdata_i[i];
    assign irq_o[i] = flag_q[i] & irq_en[i];

    assert_flag_on_expire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire[i] |=> flag_q[i]);
    assert_flag_rise_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[i]) |-> $past(expire[i]));
    assert_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr[i] && !expire[i] |=> !flag_q[i]);
  end

  // new expiry takes priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= expire | (flag_q & ~clr);
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (addr_i == ADDR_W'(REGS_PER_CH*i + OFS_CTRL))  rdata_o = ctrl_rd[i];
      if (addr_i == ADDR_W'(REGS_PER_CH*i + OFS_LOAD))  rdata_o = load_rd[i];
      if (addr_i == ADDR_W'(REGS_PER_CH*i + OFS_COUNT)) rdata_o = count_rd[i];
    end
    if (addr_i == ADDR_W'(STATUS_ADDR)) rdata_o = DATA_W'(flag_q);
  end
endmodule

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  localparam logic [31:0] RUN = 32'h4000_0000, IE = 32'h2000_0000, PER = 32'h0800_0000;

  always #10 clk = ~clk;

  ptmr_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = 3'(a); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 3'(a); #1; d = rdata;
  endtask

  function automatic logic [31:0] exp_count(int l, int p, int n, bit per);
    int k = n / (p + 1);
    if (per) return 32'(l - (k % l));
    return (k >= l) ? 32'd0 : 32'(l - k);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R11 unmapped address
    for (int a = 0; a < 7; a++) begin rd(a, v); chk("R1 reset read", v, 0); end
    chk("R1 irq after reset", 32'(irq), 0);
    rd(7, v); chk("R11 unmapped read", v, 0);

    // R2 control readback mask
    wr(3, 32'hBFFF_FFFF); rd(3, v); chk("R2 ctrl mask", v, 32'h3800_00FF);
    wr(3, 0);

    // R10 live count is read-only
    wr(1, 55); wr(2, 32'h1234);
    rd(2, v); chk("R10 count write ignored", v, 0);
    rd(1, v); chk("R11 reload readback", v, 55);

    // random runs: R3 R5 R6 R8
    for (int it = 0; it < 30; it++) begin
      int ch = $urandom_range(0, 1);
      int b = ch * 3;
      int l = $urandom_range(1, 40);
      int p = $urandom_range(0, 5);
      int n = $urandom_range(0, 300);
      bit per = 1'($urandom_range(0, 1));
      int k;
      wr(b, 0); wr(6, 3); wr(b + 1, 32'(l));
      wr(b, RUN | IE | (per ? PER : 0) | 32'(p));
      repeat (n) @(negedge clk);
      k = n / (p + 1);
      rd(b + 2, v); chk(per ? "R6 periodic count" : "R3 R5 oneshot count", v, exp_count(l, p, n, per));
      rd(6, v); chk("R7 flag after run", 32'(v[ch]), 32'(k >= l));
      chk("R8 irq follows flag", 32'(irq[ch]), 32'(k >= l));
      rd(b, v); chk("R5 run bit", 32'(v[30]), 32'(per || k < l));
    end
    wr(0, 0); wr(3, 0); wr(6, 3);

    // R9 stop holds the count
    wr(1, 100); wr(0, RUN);
    repeat (5) @(negedge clk);
    wr(0, 0);
    rd(2, v); chk("R9 count at stop", v, 94);
    repeat (10) @(negedge clk);
    rd(2, v2); chk("R9 count held", v2, v);

    // R4 restart reloads and resets prescaler phase
    wr(0, RUN | PER | 32'd3);
    repeat (10) @(negedge clk);
    wr(0, RUN | PER | 32'd3);
    rd(2, v); chk("R4 reload on start", v, 100);
    repeat (3) @(negedge clk); rd(2, v); chk("R4 no step before window", v, 100);
    @(negedge clk); rd(2, v); chk("R4 first step", v, 99);
    wr(0, 0);

    // R10 reload change mid-run applies at next reload
    wr(4, 5); wr(3, RUN | PER);
    wr(4, 9);
    repeat (3) @(negedge clk); rd(5, v); chk("R10 reload after expiry", v, 9);
    repeat (8) @(negedge clk); rd(5, v); chk("R6 second period", v, 1);
    wr(3, 0); wr(6, 3);

    // R7 expiry wins against a same-cycle clear
    wr(1, 3); wr(0, RUN | IE);
    repeat (2) @(negedge clk);
    addr = 3'd6; we = 1'b1; wdata = 32'h1;
    @(negedge clk); we = 1'b0;
    rd(6, v); chk("R7 expiry beats clear", v, 1);
    wr(6, 1); rd(6, v); chk("R7 write one clears", v, 0);

    // R7 zero bits leave flags, R8 irq gated by enable
    wr(1, 1); wr(0, RUN);
    wr(4, 1); wr(3, RUN | IE);
    repeat (4) @(negedge clk);
    rd(6, v); chk("R7 both flags", v, 3);
    chk("R8 irq gated", 32'(irq), 32'h2);
    wr(6, 2); rd(6, v); chk("R7 zero bit no effect", v, 1);
    chk("R8 irq cleared", 32'(irq), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule